// File: doc/BRIEF.md
# Once-per-Second Update Sequencer with Warning Flag and Update Interrupt

This block paces the once-per-second refresh of a clock whose time and date registers are double buffered: an internal copy that always advances, and a copy that software reads. It counts a 32768 Hz enable pulse, which arrives on the system clock, and produces one update event per second. Each event is also a transfer strobe that tells the time core to copy the internal time into the user copy.

Software can poll an update-in-progress status bit. The bit goes high a fixed number of ticks before every update (8 ticks, about 244 us, by default), so a reader that sees it low has at least that long to read a coherent time. After each transfer an update-ended status bit is set. When its enable is on, that bit drives the interrupt line, and the reader then has almost a full second before the next transfer.

A hold control blocks transfers into the user copy so that software can read or write the time without it changing. Internal timekeeping carries on while the hold is set. The first scheduled update after the hold is released copies the current internal time again. The calendar arithmetic itself sits in the time core, outside this block.

Top module: `upd_seq`

## Requirements
- R1: The divider advances only on cycles where `tick_en` is high. On every TICKS_PER_SEC-th tick after reset it raises `adv_o` for exactly one clock cycle, in the cycle after the clock edge that carries that tick. Timing is unaffected by the hold control.
- R2: Status bit 0 (update in progress) goes high on the clock edge that carries the tick exactly WARN_TICKS ticks before an update tick. In other words, it rises at count TICKS_PER_SEC-WARN_TICKS within each period.
- R3: Status bit 0 goes low on the clock edge that carries the update tick. Whenever it reads 0, at least WARN_TICKS ticks remain before the next update.
- R4: With control bit 0 (hold) at 0 on an update tick, `xfer_o` pulses for one cycle, in the same cycle as `adv_o`.
- R5: With hold at 1 on an update tick, `xfer_o` stays low and status bit 1 is not set, while `adv_o` still pulses and the divider carries on.
- R6: After hold is written back to 0, the next scheduled update issues `xfer_o` again.
- R7: Status bit 1 (update ended) is set by every transfer and is visible in the same cycle as `xfer_o`. A one-cycle `stat_rd` clears it on the following edge. If a transfer and `stat_rd` share an edge, the bit stays set.
- R8: `ctl_wr` loads control bits 0 (hold) and 1 (interrupt enable) from `ctl_wdata`, and the new values read back on `ctl_o` on the next cycle. `irq_o` is high exactly while status bit 1 and the interrupt enable are both 1.
- R9: After reset, `status_o`, `ctl_o`, `xfer_o`, `adv_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse at 32768 Hz |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 hold, bit 1 interrupt enable |
| ctl_o | output | 2 | Control register readback |
| stat_rd | input | 1 | Status read strobe; clears the update-ended bit |
| status_o | output | 2 | Bit 0 update in progress, bit 1 update ended |
| xfer_o | output | 1 | One-cycle strobe: copy internal time into the user copy |
| adv_o | output | 1 | One-cycle strobe: advance the internal time by one second |
| irq_o | output | 1 | Update-ended interrupt request |

## Verification
Every result is registered, so each output responds one clock after the edge that carries the tick, the write or the read strobe. The bench therefore drives each stimulus for a single cycle starting at a falling edge and samples at the very next falling edge. In that first sample it expects the strobes, the flag changes, the control readback and the interrupt. It samples once more a cycle later to confirm that the strobes lasted only one cycle. The expected flag level comes from the tick count modulo the period, worked out in the bench. The sweep runs every tick of several full periods on a 32-tick, 8-tick-warning configuration, and places hold writes and status reads both outside and inside the warning window and on the update tick itself.

// File: rtl/upd_pkg.sv
package upd_pkg;

  // Bit positions shared by the control and status ports
  localparam int CTL_HOLD  = 0;
  localparam int CTL_IRQEN = 1;
  localparam int ST_UIP    = 0;
  localparam int ST_UF     = 1;

  // Count value at which the warning flag is raised on the next tick
  function automatic int unsigned warn_index(input int unsigned period,
                                             input int unsigned warn);
    return period - warn - 1;
  endfunction

  // Count value carrying the update tick
  function automatic int unsigned last_index(input int unsigned period);
    return period - 1;
  endfunction

endpackage

// File: rtl/upd_divider.sv
module upd_divider #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned WARN_TICKS    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick_en,
  output logic [$clog2(TICKS_PER_SEC)-1:0]     div_q,
  output logic                                 warn_evt,
  output logic                                 upd_evt
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_AT = CW'(upd_pkg::last_index(TICKS_PER_SEC));
  localparam logic [CW-1:0] WARN_AT = CW'(upd_pkg::warn_index(TICKS_PER_SEC, WARN_TICKS));

  // Named internal events for the flag logic and the assertions
  assign upd_evt  = tick_en && (div_q == LAST_AT);
  assign warn_evt = tick_en && (div_q == WARN_AT);

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (upd_evt)  div_q <= '0;
    else if (tick_en)  div_q <= div_q + 1'b1;
  end

  p_div_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST_AT);
  p_div_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (div_q == '0));
  p_div_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(div_q));

endmodule

// File: rtl/upd_ctl.sv
module upd_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic       hold_q,
  output logic       irq_en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (ctl_wr) begin
      hold_q   <= ctl_wdata[upd_pkg::CTL_HOLD];
      irq_en_q <= ctl_wdata[upd_pkg::CTL_IRQEN];
    end
  end

  p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (hold_q == $past(ctl_wdata[upd_pkg::CTL_HOLD])) &&
               (irq_en_q == $past(ctl_wdata[upd_pkg::CTL_IRQEN])));
  p_ctl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(hold_q) && $stable(irq_en_q));

endmodule

// File: rtl/upd_flags.sv
module upd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_evt,
  input  logic upd_evt,
  input  logic hold,
  input  logic irq_en,
  input  logic stat_rd,
  output logic uip_q,
  output logic uf_q,
  output logic xfer_q,
  output logic adv_q,
  output logic irq_o
);
  logic xfer_set;
  assign xfer_set = upd_evt && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q  <= 1'b0;
      uf_q   <= 1'b0;
      xfer_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      adv_q  <= upd_evt;
      xfer_q <= xfer_set;
      if (upd_evt)       uip_q <= 1'b0;
      else if (warn_evt) uip_q <= 1'b1;
      if (xfer_set)      uf_q  <= 1'b1;
      else if (stat_rd)  uf_q  <= 1'b0;
    end
  end

  assign irq_o = uf_q && irq_en;

  p_uip_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |=> uip_q);
  p_uip_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!warn_evt && !upd_evt) |=> $stable(uip_q));
  p_uip_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> !uip_q);
  p_xfer_with_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |-> adv_q);
  p_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && hold) |=> adv_q && !xfer_q && (uf_q == $past(uf_q && !stat_rd)));
  p_uf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !hold) |=> uf_q);
  p_uf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !upd_evt) |=> !uf_q);

endmodule

// File: rtl/upd_seq.sv
module upd_seq #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned WARN_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic [1:0] ctl_o,
  input  logic       stat_rd,
  output logic [1:0] status_o,
  output logic       xfer_o,
  output logic       adv_o,
  output logic       irq_o
);
  localparam int CW = $clog2(TICKS_PER_SEC);

  logic [CW-1:0] div_q;
  logic          warn_evt;
  logic          upd_evt;
  logic          hold_q;
  logic          irq_en_q;
  logic          uip_q;
  logic          uf_q;

  upd_divider #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .WARN_TICKS   (WARN_TICKS)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .div_q   (div_q),
    .warn_evt(warn_evt),
    .upd_evt (upd_evt)
  );

  upd_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .hold_q   (hold_q),
    .irq_en_q (irq_en_q)
  );

  upd_flags u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .warn_evt(warn_evt),
    .upd_evt (upd_evt),
    .hold    (hold_q),
    .irq_en  (irq_en_q),
    .stat_rd (stat_rd),
    .uip_q   (uip_q),
    .uf_q    (uf_q),
    .xfer_q  (xfer_o),
    .adv_q   (adv_o),
    .irq_o   (irq_o)
  );

  always_comb begin
    ctl_o    = '0;
    status_o = '0;
    ctl_o[upd_pkg::CTL_HOLD]  = hold_q;
    ctl_o[upd_pkg::CTL_IRQEN] = irq_en_q;
    status_o[upd_pkg::ST_UIP] = uip_q;
    status_o[upd_pkg::ST_UF]  = uf_q;
  end

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o[upd_pkg::ST_UF] && ctl_o[upd_pkg::CTL_IRQEN]);
  p_adv_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o);

endmodule

// File: tb/upd_seq_test.sv
`timescale 1ns/1ps
module upd_seq_test;
  localparam int N = 32;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       ctl_wr;
  logic [1:0] ctl_wdata;
  logic [1:0] ctl_o;
  logic       stat_rd;
  logic [1:0] status_o;
  logic       xfer_o;
  logic       adv_o;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model
  int t      = 0;
  bit m_hold = 0;
  bit m_en   = 0;
  bit m_uf   = 0;
  bit m_rel  = 0;

  always #5 clk = ~clk;

  upd_seq #(.TICKS_PER_SEC(N), .WARN_TICKS(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_o(ctl_o),
    .stat_rd(stat_rd), .status_o(status_o),
    .xfer_o(xfer_o), .adv_o(adv_o), .irq_o(irq_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", tag, act, exp, t);
    end
  endtask

  task automatic check_flags();
    int m = t % N;
    chk(int'(status_o[0]), (m >= N - W) ? 1 : 0,
        (m >= N - W) ? "R2 update-in-progress high in window" : "R3 update-in-progress low outside window");
    chk(int'(status_o[1]), int'(m_uf), "R7 update-ended flag");
    chk(int'(irq_o), int'(m_uf && m_en), "R8 irq is flag and enable");
  endtask

  task automatic do_tick(input bit rd);
    bit ev;
    bit xf;
    string xtag;
    tick_en = 1'b1;
    stat_rd = rd;
    @(negedge clk);
    tick_en = 1'b0;
    stat_rd = 1'b0;
    t++;
    ev = (t % N) == 0;
    xf = ev && !m_hold;
    if (xf) m_uf = 1'b1;
    else if (rd) m_uf = 1'b0;
    xtag = (ev && m_hold) ? "R5 transfer suppressed while held" :
           (ev && m_rel)  ? "R6 transfer resumes after hold release" :
                            "R4 transfer strobe";
    chk(int'(adv_o), int'(ev), "R1 advance strobe on update tick");
    chk(int'(xfer_o), int'(xf), xtag);
    check_flags();
    @(negedge clk);
    chk(int'(adv_o), 0, "R1 advance strobe lasts one cycle");
    chk(int'(xfer_o), 0, "R4 transfer strobe lasts one cycle");
    if (ev) m_rel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b0);
  endtask

  task automatic write_ctl(input logic [1:0] v);
    ctl_wr    = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (m_hold && !v[0]) m_rel = 1'b1;
    m_hold = v[0];
    m_en   = v[1];
    chk(int'(ctl_o), int'(v), "R8 control readback");
    check_flags();
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    m_uf = 1'b0;
    check_flags();
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(int'(status_o), 0, "R9 status after reset");
    chk(int'(ctl_o), 0, "R9 control after reset");
    chk(int'(xfer_o), 0, "R9 transfer after reset");
    chk(int'(adv_o), 0, "R9 advance after reset");
    chk(int'(irq_o), 0, "R9 irq after reset");
    // R1 no ticks, no progress
    repeat (40) @(negedge clk);
    chk(int'(status_o), 0, "R1 idle without ticks");
    // first full period, interrupt disabled
    ticks(N);
    write_ctl(2'b10);          // enable interrupt: R8 irq rises
    read_status();             // R7 clear on read
    // hold set mid-period, update held
    ticks(N / 2);
    write_ctl(2'b11);
    ticks(N / 2);              // R5
    chk(int'(status_o[0]), 0, "R5 counting continues while held");
    write_ctl(2'b10);          // release
    ticks(N);                  // R6 transfer resumes
    // read coinciding with the update edge
    ticks(N - 1);
    do_tick(1'b1);             // R7 set wins
    read_status();
    // hold written inside the warning window
    ticks(N - W / 2);
    write_ctl(2'b11);
    ticks(W / 2);              // R5
    write_ctl(2'b00);
    ticks(N);                  // R6, irq disabled
    read_status();
    ticks(N);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule